// File: doc/BRIEF.md
# DMA Source Address Sequencer

This block keeps the source address of one DMA channel and moves it by one step for each completed transfer. The step follows a 2-bit update mode. The address can stay fixed, count up or count down. The step size is one for a byte transfer and two for a word transfer. When the source is an external handshaking device in single-address mode, the address never moves.

An optional repeat area limits the movement to a window of 2^N bytes. Inside that window the low N address bits wrap around, and the upper bits stay as they are. A wrap counts as an overflow. If stopping on overflow is enabled, the block halts the channel. It sends a one-cycle enable-clear pulse and latches an interrupt flag. In block transfer mode the halt is held back until the transfer that ends the current block. After a halt, software sets the enable again and transfers continue from the address that was reached, without any reload.

The control path is a three-state machine with these states:
- `SAS_RUN`: normal stepping.
- `SAS_PEND`: an overflow was seen in block mode and the block has not finished yet. Stepping goes on.
- `SAS_HALT`: transfer strobes are ignored.

The transitions are:
- RUN→HALT: overflow outside block mode, or overflow on the block-ending transfer.
- RUN→PEND: overflow in the middle of a block.
- PEND→HALT: the block-ending transfer arrives.
- HALT→RUN: enable-set.

Top module: `src_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0, `irq_o` and `en_clr_o` are 0, and the machine is in `SAS_RUN`.
- R2: A high `ld_i` at a clock edge loads `start_addr_i` into `addr_o`. Load has priority over a transfer strobe in the same cycle.
- R3: With `upd_mode_i` equal to 00 or 01 (fixed), a transfer leaves `addr_o` unchanged.
- R4: With `upd_mode_i` = 10, a transfer adds 1 (`word_i`=0) or 2 (`word_i`=1). With 11, it subtracts the same amount. The new value shows after the edge that samples `xfer_done_i`.
- R5: While `single_ext_i` is 1, a transfer leaves `addr_o` unchanged in every mode.
- R6: With `rpt_en_i`=1 and N=`rpt_bits_i`, only the low N bits change on a step. They wrap from all-ones to zero on increment, and from zero to all-ones on decrement. The upper bits are kept.
- R7: A wrap under R6 with `rpt_irq_en_i`=1 and `blk_mode_i`=0 moves the machine to `SAS_HALT`. `irq` flag is set and `en_clr_o` is high for exactly the cycle after that edge. Further transfer strobes leave `addr_o` unchanged.
- R8: With `blk_mode_i`=1, a wrap before the block ends does not halt the channel, and stepping continues. The halt, flag and pulse of R7 happen on the transfer that carries `blk_end_i`=1.
- R9: `irq_o` equals the interrupt flag ANDed with `irq_ie_i`.
- R10: In `SAS_HALT`, a pulse on `en_set_i` returns the machine to `SAS_RUN`. The next transfer steps on from the address held at the halt.
- R11: With `rpt_en_i`=0, `rpt_irq_en_i` has no effect. The address moves over the full 24 bits, wrapping modulo 2^24, and never halts.
- R12: The interrupt flag stays set until `flag_clr_i` is high at an edge. A new halt in that same cycle wins over the clear.
- R13: With `rpt_en_i`=1 and `rpt_irq_en_i`=0, a wrap steps the address but raises no pulse or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_i | input | 1 | Load start address |
| start_addr_i | input | 24 | Start address |
| upd_mode_i | input | 2 | Update mode: 0x fixed, 10 up, 11 down |
| word_i | input | 1 | 1 = word transfer (step 2), 0 = byte (step 1) |
| single_ext_i | input | 1 | Source is an external handshaking device in single-address mode |
| rpt_en_i | input | 1 | Repeat area configured |
| rpt_bits_i | input | 5 | N: repeat window is 2^N bytes |
| rpt_irq_en_i | input | 1 | Stop and flag on repeat overflow |
| blk_mode_i | input | 1 | Block transfer mode |
| blk_end_i | input | 1 | Qualifies the transfer that ends a block |
| xfer_done_i | input | 1 | One-cycle strobe per completed transfer |
| en_set_i | input | 1 | Software sets the channel enable (resume) |
| irq_ie_i | input | 1 | Channel interrupt enable |
| flag_clr_i | input | 1 | Clear the interrupt flag |
| addr_o | output | 24 | Current source address |
| en_clr_o | output | 1 | One-cycle pulse that clears the channel enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at window-edge wraps in both directions. A design that carries into the upper bits would leave the window instead of wrapping to its base. A design that halts mid-block would stop the block early. One that forgets the held address on resume would restart from a stale or reloaded value. The bench also runs the case with no repeat area and stopping enabled: a full-width rollover there must not halt, and a faulty decode would stop the channel for nothing. Word steps that cross the window edge, and the single-address override under a counting mode, catch step-size and mode-priority mistakes.

// File: rtl/src_addr_seq_pkg.sv
package src_addr_seq_pkg;
    typedef enum logic [1:0] {
        SAS_RUN  = 2'd0,
        SAS_PEND = 2'd1,
        SAS_HALT = 2'd2
    } sas_state_e;
endpackage

// File: rtl/sas_step_calc.sv
module sas_step_calc #(
    parameter int AW = 24,
    parameter int NW = 5
) (
    input  logic [AW-1:0] addr_q,
    input  logic [1:0]    mode,
    input  logic          word,
    input  logic          single_ext,
    input  logic          rpt_en,
    input  logic [NW-1:0] rpt_bits,
    output logic [AW-1:0] next_addr,
    output logic          ovf
);
    localparam int XW = AW + 1;

    logic [XW-1:0] base_x;
    logic [XW-1:0] step_x;
    logic [XW-1:0] raw_x;
    logic [XW-1:0] mask_x;
    logic [XW-1:0] merged_x;
    logic          moving;

    always_comb begin
        base_x   = {1'b0, addr_q};
        step_x   = word ? XW'(2) : XW'(1);
        mask_x   = rpt_en ? ((XW'(1) << rpt_bits) - XW'(1)) : {XW{1'b1}};
        moving   = !single_ext && mode[1];
        raw_x    = mode[0] ? (base_x - step_x) : (base_x + step_x);
        merged_x = (base_x & ~mask_x) | (raw_x & mask_x);
        next_addr = moving ? merged_x[AW-1:0] : addr_q;
        ovf = moving && rpt_en && ((raw_x & ~mask_x) != (base_x & ~mask_x));
    end
endmodule

// File: rtl/sas_ctrl_fsm.sv
module sas_ctrl_fsm
    import src_addr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer,
    input  logic       ovf,
    input  logic       rpt_irq_en,
    input  logic       blk_mode,
    input  logic       blk_end,
    input  logic       en_set,
    input  logic       flag_clr,
    output logic       accept,
    output logic       halted,
    output logic       flag,
    output logic       en_clr
);
    sas_state_e state_q, state_d;
    logic       stop_now;
    logic       trip;

    always_comb begin
        accept   = xfer && (state_q != SAS_HALT);
        trip     = accept && ovf && rpt_irq_en;
        stop_now = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            SAS_RUN: begin
                if (trip && (!blk_mode || blk_end)) begin
                    stop_now = 1'b1;
                    state_d  = SAS_HALT;
                end else if (trip) begin
                    state_d  = SAS_PEND;
                end
            end
            SAS_PEND: begin
                if (accept && blk_end) begin
                    stop_now = 1'b1;
                    state_d  = SAS_HALT;
                end
            end
            SAS_HALT: begin
                if (en_set) state_d = SAS_RUN;
            end
            default: state_d = SAS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SAS_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            en_clr <= 1'b0;
        end else begin
            en_clr <= stop_now;
            if (stop_now)      flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    assign halted = (state_q == SAS_HALT);
endmodule

// File: rtl/src_addr_seq.sv
module src_addr_seq #(
    parameter int AW = 24,
    parameter int NW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [1:0]    upd_mode_i,
    input  logic          word_i,
    input  logic          single_ext_i,
    input  logic          rpt_en_i,
    input  logic [NW-1:0] rpt_bits_i,
    input  logic          rpt_irq_en_i,
    input  logic          blk_mode_i,
    input  logic          blk_end_i,
    input  logic          xfer_done_i,
    input  logic          en_set_i,
    input  logic          irq_ie_i,
    input  logic          flag_clr_i,
    output logic [AW-1:0] addr_o,
    output logic          en_clr_o,
    output logic          irq_o
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] next_addr;
    logic          ovf;
    logic          accept;
    logic          halted;
    logic          flag_q;

    sas_step_calc #(.AW(AW), .NW(NW)) u_step (
        .addr_q     (addr_q),
        .mode       (upd_mode_i),
        .word       (word_i),
        .single_ext (single_ext_i),
        .rpt_en     (rpt_en_i),
        .rpt_bits   (rpt_bits_i),
        .next_addr  (next_addr),
        .ovf        (ovf)
    );

    sas_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer_done_i && !ld_i),
        .ovf        (ovf),
        .rpt_irq_en (rpt_irq_en_i),
        .blk_mode   (blk_mode_i),
        .blk_end    (blk_end_i),
        .en_set     (en_set_i),
        .flag_clr   (flag_clr_i),
        .accept     (accept),
        .halted     (halted),
        .flag       (flag_q),
        .en_clr     (en_clr_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q <= '0;
        else if (ld_i)   addr_q <= start_addr_i;
        else if (accept) addr_q <= next_addr;
    end

    assign addr_o = addr_q;
    assign irq_o  = flag_q && irq_ie_i;
endmodule

// File: rtl/sas_chk.sv
module sas_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_i,
    input logic [AW-1:0] start_addr_i,
    input logic [1:0]    upd_mode_i,
    input logic          single_ext_i,
    input logic          xfer_done_i,
    input logic          flag_clr_i,
    input logic          irq_ie_i,
    input logic [AW-1:0] addr_o,
    input logic          en_clr_o,
    input logic          irq_o,
    input logic          halted,
    input logic          flag_q
);
    // R2
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (addr_o == $past(start_addr_i)));

    // R3
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && !ld_i && !upd_mode_i[1]) |=> $stable(addr_o));

    // R5
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && !ld_i && single_ext_i) |=> $stable(addr_o));

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && xfer_done_i && !ld_i) |=> $stable(addr_o));

    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_o |=> !en_clr_o);

    // R7
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_o |-> flag_q);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_ie_i);

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);
endmodule

bind src_addr_seq sas_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_i         (ld_i),
    .start_addr_i (start_addr_i),
    .upd_mode_i   (upd_mode_i),
    .single_ext_i (single_ext_i),
    .xfer_done_i  (xfer_done_i),
    .flag_clr_i   (flag_clr_i),
    .irq_ie_i     (irq_ie_i),
    .addr_o       (addr_o),
    .en_clr_o     (en_clr_o),
    .irq_o        (irq_o),
    .halted       (halted),
    .flag_q       (flag_q)
);

// File: tb/src_addr_seq_tb.sv
`timescale 1ns/1ps
module src_addr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_i, word_i, single_ext_i, rpt_en_i, rpt_irq_en_i;
    logic        blk_mode_i, blk_end_i, xfer_done_i, en_set_i, irq_ie_i, flag_clr_i;
    logic [23:0] start_addr_i;
    logic [1:0]  upd_mode_i;
    logic [4:0]  rpt_bits_i;
    logic [23:0] addr_o;
    logic        en_clr_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    src_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .start_addr_i(start_addr_i),
        .upd_mode_i(upd_mode_i), .word_i(word_i), .single_ext_i(single_ext_i),
        .rpt_en_i(rpt_en_i), .rpt_bits_i(rpt_bits_i), .rpt_irq_en_i(rpt_irq_en_i),
        .blk_mode_i(blk_mode_i), .blk_end_i(blk_end_i), .xfer_done_i(xfer_done_i),
        .en_set_i(en_set_i), .irq_ie_i(irq_ie_i), .flag_clr_i(flag_clr_i),
        .addr_o(addr_o), .en_clr_o(en_clr_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [23:0] a);
        start_addr_i = a; ld_i = 1'b1;
        @(negedge clk);
        ld_i = 1'b0;
    endtask

    task automatic xfer(input logic w, input logic be);
        word_i = w; blk_end_i = be; xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0; blk_end_i = 1'b0;
    endtask

    task automatic pulse_set();
        en_set_i = 1'b1; @(negedge clk); en_set_i = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 addr", addr_o, 24'h0);
        chk("R1 irq", {23'b0, irq_o}, 24'h0);
        chk("R1 en_clr", {23'b0, en_clr_o}, 24'h0);
    endtask

    task automatic t_load_fixed();
        load(24'h123456);
        chk("R2 load", addr_o, 24'h123456);
        upd_mode_i = 2'b00; xfer(1'b1, 1'b0);
        chk("R3 fixed 00", addr_o, 24'h123456);
        upd_mode_i = 2'b01; xfer(1'b0, 1'b0);
        chk("R3 fixed 01", addr_o, 24'h123456);
        upd_mode_i = 2'b10; start_addr_i = 24'h000500; ld_i = 1'b1;
        xfer(1'b0, 1'b0); ld_i = 1'b0;
        chk("R2 load priority", addr_o, 24'h000500);
    endtask

    task automatic t_step();
        load(24'h000010);
        upd_mode_i = 2'b10; xfer(1'b0, 1'b0);
        chk("R4 inc byte", addr_o, 24'h000011);
        xfer(1'b1, 1'b0);
        chk("R4 inc word", addr_o, 24'h000013);
        upd_mode_i = 2'b11; xfer(1'b1, 1'b0);
        chk("R4 dec word", addr_o, 24'h000011);
        xfer(1'b0, 1'b0);
        chk("R4 dec byte", addr_o, 24'h000010);
    endtask

    task automatic t_single();
        upd_mode_i = 2'b10; single_ext_i = 1'b1;
        xfer(1'b1, 1'b0);
        chk("R5 single inc", addr_o, 24'h000010);
        upd_mode_i = 2'b11; xfer(1'b0, 1'b0);
        chk("R5 single dec", addr_o, 24'h000010);
        single_ext_i = 1'b0;
    endtask

    task automatic t_wrap_noirq();
        rpt_en_i = 1'b1; rpt_bits_i = 5'd4; rpt_irq_en_i = 1'b0;
        load(24'hAB001F);
        upd_mode_i = 2'b10; xfer(1'b0, 1'b0);
        chk("R6 inc wrap", addr_o, 24'hAB0010);
        chk("R13 no pulse", {23'b0, en_clr_o}, 24'h0);
        upd_mode_i = 2'b11; xfer(1'b0, 1'b0);
        chk("R6 dec wrap", addr_o, 24'hAB001F);
        chk("R13 no irq", {23'b0, irq_o}, 24'h0);
    endtask

    task automatic t_halt();
        rpt_irq_en_i = 1'b1; irq_ie_i = 1'b1; blk_mode_i = 1'b0;
        load(24'h00003E);
        upd_mode_i = 2'b10; xfer(1'b1, 1'b0);
        chk("R7 wrap addr", addr_o, 24'h000030);
        chk("R7 pulse", {23'b0, en_clr_o}, 24'h1);
        chk("R7 irq", {23'b0, irq_o}, 24'h1);
        @(negedge clk);
        chk("R7 pulse one cycle", {23'b0, en_clr_o}, 24'h0);
        xfer(1'b1, 1'b0);
        chk("R7 halted freeze", addr_o, 24'h000030);
        repeat (3) @(negedge clk);
        chk("R12 flag held", {23'b0, irq_o}, 24'h1);
        irq_ie_i = 1'b0; #1;
        chk("R9 masked", {23'b0, irq_o}, 24'h0);
        irq_ie_i = 1'b1; #1;
        chk("R9 unmasked", {23'b0, irq_o}, 24'h1);
        pulse_clr();
        chk("R12 cleared", {23'b0, irq_o}, 24'h0);
        pulse_set();
        xfer(1'b1, 1'b0);
        chk("R10 resume", addr_o, 24'h000032);
        chk("R10 no new stop", {23'b0, en_clr_o}, 24'h0);
    endtask

    task automatic t_block();
        blk_mode_i = 1'b1;
        load(24'h00000F);
        upd_mode_i = 2'b10; xfer(1'b0, 1'b0);
        chk("R8 wrap mid-block", addr_o, 24'h000000);
        chk("R8 no early pulse", {23'b0, en_clr_o}, 24'h0);
        xfer(1'b0, 1'b0);
        chk("R8 keeps stepping", addr_o, 24'h000001);
        chk("R8 no early irq", {23'b0, irq_o}, 24'h0);
        xfer(1'b0, 1'b1);
        chk("R8 last of block", addr_o, 24'h000002);
        chk("R8 pulse at end", {23'b0, en_clr_o}, 24'h1);
        chk("R8 irq at end", {23'b0, irq_o}, 24'h1);
        xfer(1'b0, 1'b0);
        chk("R8 halted", addr_o, 24'h000002);
        pulse_clr(); pulse_set(); blk_mode_i = 1'b0;
    endtask

    task automatic t_norpt();
        rpt_en_i = 1'b0; rpt_irq_en_i = 1'b1;
        load(24'hFFFFFF);
        upd_mode_i = 2'b10; xfer(1'b0, 1'b0);
        chk("R11 full rollover", addr_o, 24'h000000);
        chk("R11 no pulse", {23'b0, en_clr_o}, 24'h0);
        load(24'h00001F); xfer(1'b0, 1'b0);
        chk("R11 no window", addr_o, 24'h000020);
        chk("R11 no irq", {23'b0, irq_o}, 24'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ld_i = 0; word_i = 0; single_ext_i = 0; rpt_en_i = 0;
        rpt_irq_en_i = 0; blk_mode_i = 0; blk_end_i = 0; xfer_done_i = 0;
        en_set_i = 0; irq_ie_i = 0; flag_clr_i = 0; start_addr_i = '0;
        upd_mode_i = 2'b00; rpt_bits_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_fixed();
        t_step();
        t_single();
        t_wrap_noirq();
        t_halt();
        t_block();
        t_norpt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule